// File: doc/BRIEF.md
# Direct-mapped window address translator

This block turns a virtual address into a physical address through a small set of fixed mapping windows, so that no TLB lookup is needed. It keeps four window registers, and a CSR-style write port loads them. Each window names a virtual segment and the privilege levels allowed to use it. In 32-bit mode a window also names a physical segment.

A lookup presents a virtual address, a kernel/user flag and a mode flag. The windows are compared in parallel and the lowest-numbered matching window wins. The block returns a hit flag, the translated address, the window's 2-bit memory access type and a read/write/execute grant.

In 32-bit mode the physical segment replaces the top three address bits. In 64-bit mode the address is only cut down to the implemented virtual address width. On a miss every result output is zero, so a separate TLB path can handle the address. The lookup is combinational from the registered window state.

Top module: `dmw_translate`

## Requirements
- R1: After reset every window register is zero, so every lookup misses until a window is written.
- R2: A kernel lookup (lk_user=0) can hit only a window whose bit 0 is 1. A user lookup (lk_user=1) can hit only a window whose bit 3 is 1.
- R3: In 32-bit mode (lk_mode64=0) a window matches when lk_va[31:29] equals window bits 31:29.
- R4: On a 32-bit hit, pa equals {32'b0, window bits 27:25, lk_va[28:0]}.
- R5: In 64-bit mode (lk_mode64=1) a window matches when lk_va[63:60] equals window bits 63:60.
- R6: On a 64-bit hit, pa equals lk_va with every bit at or above VA_WIDTH (default 48) cleared. No segment is substituted.
- R7: When several windows match, window 0 has the highest priority and window 3 the lowest. The highest-priority match supplies the result.
- R8: A hit drives perm_r, perm_w and perm_x all to 1, and drives mat to window bits 5:4.
- R9: A miss drives hit, pa, mat and all three permission outputs to zero.
- R10: A write with wr_en=1 loads wr_data into window wr_idx at the next clock edge. A lookup in the following cycle sees the new value. The other windows are unchanged.
- R11: The upper address half lk_va[63:32] plays no part in a 32-bit lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Window register write enable |
| wr_idx | input | 2 | Window index to write |
| wr_data | input | 64 | Window register write value |
| lk_va | input | 64 | Lookup virtual address |
| lk_user | input | 1 | 1 = user privilege, 0 = kernel |
| lk_mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| hit | output | 1 | A window matched |
| pa | output | 64 | Translated physical address |
| mat | output | 2 | Memory access type of the matching window |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |

## Verification
The hardest case to reach is the priority between windows. Several windows must match the same address at once, and the result must then move to the next window when the winner is rewritten. The stimulus first programs two windows with the same 64-bit virtual segment but different access types and checks that the lower index wins. It then clears that window and checks in the very next cycle that the higher index takes over. It also sets up a window that matches on segment but not on privilege, so the privilege bits are shown to block it. In the same window the segment fields of the other mode are left nonzero, so the field selection by mode is exercised too.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  localparam int XLEN       = 64;
  localparam int PRIV_K_BIT = 0;
  localparam int PRIV_U_BIT = 3;
  localparam int MAT_LSB    = 4;
  localparam int MAT_W      = 2;
  localparam int SEG32_W    = 3;
  localparam int VSEG32_LSB = 29;
  localparam int PSEG32_LSB = 25;
  localparam int SEG64_W    = 4;
  localparam int VSEG64_LSB = 60;

  typedef struct packed {
    logic              hit;
    logic [XLEN-1:0]   pa;
    logic [MAT_W-1:0]  mat;
  } dmw_result_t;
endpackage

// File: rtl/dmw_regs.sv
module dmw_regs #(
  parameter int NWIN = 4,
  parameter int XW   = 64,
  localparam int IDXW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDXW-1:0]          wr_idx,
  input  logic [XW-1:0]            wr_data,
  output logic [NWIN-1:0][XW-1:0]  win_q
);
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst)
        win_q[i] <= '0;
      else if (wr_en && (wr_idx == IDXW'(i)))
        win_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/dmw_match.sv
module dmw_match
  import dmw_pkg::*;
#(
  parameter int VA_WIDTH = 48
) (
  input  logic [XLEN-1:0] win,
  input  logic [XLEN-1:0] va,
  input  logic            user,
  input  logic            mode64,
  output dmw_result_t     res
);
  localparam logic [XLEN-1:0] VA_MASK =
    (VA_WIDTH >= XLEN) ? {XLEN{1'b1}} : ((64'd1 << VA_WIDTH) - 64'd1);

  logic            priv_ok;
  logic            seg_ok;
  logic [XLEN-1:0] pa32;
  logic [XLEN-1:0] pa64;
  logic            unused_win_bits;

  assign priv_ok = user ? win[PRIV_U_BIT] : win[PRIV_K_BIT];

  always_comb begin
    if (mode64)
      seg_ok = (va[VSEG64_LSB +: SEG64_W] == win[VSEG64_LSB +: SEG64_W]);
    else
      seg_ok = (va[VSEG32_LSB +: SEG32_W] == win[VSEG32_LSB +: SEG32_W]);
  end

  assign pa32 = {32'b0, win[PSEG32_LSB +: SEG32_W], va[VSEG32_LSB-1:0]};
  assign pa64 = va & VA_MASK;

  always_comb begin
    res.hit = priv_ok && seg_ok;
    res.pa  = '0;
    res.mat = '0;
    if (res.hit) begin
      res.pa  = mode64 ? pa64 : pa32;
      res.mat = win[MAT_LSB +: MAT_W];
    end
  end

  assign unused_win_bits = ^{win[59:32], win[28], win[24:6], win[2:1]};
endmodule

// File: rtl/dmw_pick.sv
module dmw_pick
  import dmw_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  dmw_result_t [NWIN-1:0] cand,
  output dmw_result_t            sel
);
  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (cand[i].hit) sel = cand[i];
    end
  end
endmodule

// File: rtl/dmw_translate.sv
module dmw_translate
  import dmw_pkg::*;
#(
  parameter int NWIN     = 4,
  parameter int VA_WIDTH = 48
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_idx,
  input  logic [63:0] wr_data,
  input  logic [63:0] lk_va,
  input  logic        lk_user,
  input  logic        lk_mode64,
  output logic        hit,
  output logic [63:0] pa,
  output logic [1:0]  mat,
  output logic        perm_r,
  output logic        perm_w,
  output logic        perm_x
);
  logic [NWIN-1:0][XLEN-1:0] win_q;
  dmw_result_t [NWIN-1:0]    cand;
  dmw_result_t               sel;

  dmw_regs #(.NWIN(NWIN), .XW(XLEN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .win_q   (win_q)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_match
    dmw_match #(.VA_WIDTH(VA_WIDTH)) u_match (
      .win    (win_q[i]),
      .va     (lk_va),
      .user   (lk_user),
      .mode64 (lk_mode64),
      .res    (cand[i])
    );
  end

  dmw_pick #(.NWIN(NWIN)) u_pick (
    .cand (cand),
    .sel  (sel)
  );

  assign hit    = sel.hit;
  assign pa     = sel.pa;
  assign mat    = sel.mat;
  assign perm_r = sel.hit;
  assign perm_w = sel.hit;
  assign perm_x = sel.hit;
endmodule

// File: rtl/dmw_translate_chk.sv
module dmw_translate_chk #(
  parameter int VA_WIDTH = 48
) (
  input logic        clk,
  input logic        rst,
  input logic [63:0] lk_va,
  input logic        lk_mode64,
  input logic        hit,
  input logic [63:0] pa,
  input logic [1:0]  mat,
  input logic        perm_r,
  input logic        perm_w,
  input logic        perm_x
);
  localparam logic [63:0] MASK =
    (VA_WIDTH >= 64) ? {64{1'b1}} : ((64'd1 << VA_WIDTH) - 64'd1);

  assert_reset_miss_R1: assert property (@(posedge clk)
    $fell(rst) |-> !hit);

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (pa == 64'd0 && mat == 2'd0 && !perm_r && !perm_w && !perm_x));

  assert_hit_rwx_R8: assert property (@(posedge clk) disable iff (rst)
    hit |-> (perm_r && perm_w && perm_x));

  assert_pa32_low_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && !lk_mode64) |-> (pa[28:0] == lk_va[28:0] && pa[63:32] == 32'd0));

  assert_pa64_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && lk_mode64) |-> (pa == (lk_va & MASK)));
endmodule

bind dmw_translate dmw_translate_chk #(.VA_WIDTH(VA_WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_va     (lk_va),
  .lk_mode64 (lk_mode64),
  .hit       (hit),
  .pa        (pa),
  .mat       (mat),
  .perm_r    (perm_r),
  .perm_w    (perm_w),
  .perm_x    (perm_x)
);

// File: tb/dmw_translate_tb.sv
`timescale 1ns/1ps
module dmw_translate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = 2'd0;
  logic [63:0] wr_data = 64'd0;
  logic [63:0] lk_va = 64'd0;
  logic        lk_user = 1'b0;
  logic        lk_mode64 = 1'b0;
  logic        hit;
  logic [63:0] pa;
  logic [1:0]  mat;
  logic        perm_r, perm_w, perm_x;

  always #2 clk = ~clk;

  dmw_translate u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lk_va(lk_va), .lk_user(lk_user), .lk_mode64(lk_mode64),
    .hit(hit), .pa(pa), .mat(mat),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  typedef struct {
    logic        hit;
    logic [63:0] pa;
    logic [1:0]  mat;
    logic [2:0]  perm;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] model_win [4];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  function automatic exp_t predict(input logic [63:0] va, input logic user,
                                   input logic m64, input string tag);
    exp_t e;
    e.hit = 0; e.pa = 64'd0; e.mat = 2'd0; e.perm = 3'b000; e.tag = tag;
    for (int i = 3; i >= 0; i--) begin
      logic pok, sok;
      pok = user ? model_win[i][3] : model_win[i][0];
      sok = m64 ? (va[63:60] == model_win[i][63:60])
                : (va[31:29] == model_win[i][31:29]);
      if (pok && sok) begin
        e.hit  = 1;
        e.mat  = model_win[i][5:4];
        e.perm = 3'b111;
        e.pa   = m64 ? (va & 64'h0000_FFFF_FFFF_FFFF)
                     : {32'd0, model_win[i][27:25], va[28:0]};
      end
    end
    return e;
  endfunction

  task automatic wr(input logic [1:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_win[idx] = d;
  endtask

  task automatic look(input logic [63:0] va, input logic user,
                      input logic m64, input string tag);
    lk_va = va; lk_user = user; lk_mode64 = m64;
    sb.push_back(predict(va, user, m64, tag));
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (hit !== e.hit || pa !== e.pa || mat !== e.mat ||
          {perm_r, perm_w, perm_x} !== e.perm) begin
        n_bad++;
        $display("FAIL %s: got hit=%0b pa=%h mat=%0d perm=%b, expected hit=%0b pa=%h mat=%0d perm=%b",
                 e.tag, hit, pa, mat, {perm_r, perm_w, perm_x},
                 e.hit, e.pa, e.mat, e.perm);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model_win[i] = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 R9: all windows clear after reset
    look(64'h0000_0000_0000_0000, 0, 0, "R1 reset miss 32");
    look(64'h0000_0000_0000_0000, 0, 1, "R1 R9 reset miss 64");
    // window0: vseg32=4, pseg32=0, mat=1, kernel; also vseg64 = 1 (other mode field)
    wr(2'd0, 64'h1000_0000_8000_0011);
    look(64'h0000_0000_9234_5678, 0, 0, "R3 R4 R8 win0 32-bit hit");
    look(64'h0000_0000_9234_5678, 1, 0, "R2 user blocked on kernel window");
    look(64'h0000_0000_A000_0000, 0, 0, "R3 segment mismatch miss");
    // window1: vseg32=5, pseg32=3, mat=2, user only
    wr(2'd1, 64'h0000_0000_A600_0028);
    look(64'h0000_0000_B111_2222, 1, 0, "R4 R8 win1 user hit");
    look(64'h0000_0000_B111_2222, 0, 0, "R2 kernel blocked on user window");
    look(64'hFFFF_FFFF_B111_2222, 1, 0, "R11 upper half ignored in 32-bit");
    // window2: vseg64=9, mat=3, kernel
    wr(2'd2, 64'h9000_0000_0000_0031);
    look(64'h9000_1234_5678_9ABC, 0, 1, "R5 R6 win2 64-bit hit masked");
    look(64'h1FFF_FFFF_FFFF_FFFF, 0, 1, "R5 R6 win0 vseg64 hit");
    look(64'hA000_0000_9234_5678, 0, 1, "R5 R9 64-bit miss");
    // window3 overlaps window2
    wr(2'd3, 64'h9000_0000_0000_0001);
    look(64'h9000_0000_0000_0040, 0, 1, "R7 window2 beats window3");
    wr(2'd2, 64'h0000_0000_0000_0000);
    look(64'h9000_0000_0000_0040, 0, 1, "R10 R7 window3 after clear");
    look(64'h0000_0000_B111_2222, 1, 0, "R10 window1 untouched");
    // priority in 32-bit mode: window1 made to also match vseg 4 for user and kernel
    wr(2'd1, 64'h0000_0000_8E00_0029);
    look(64'h0000_0000_8000_0004, 0, 0, "R7 window0 beats window1 32-bit");
    look(64'h0000_0000_8000_0004, 1, 0, "R2 R7 user falls to window1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule